// File: doc/BRIEF.md
# Scanline-Paced Interrupt Timer

This block generates a periodic interrupt for a cartridge-side bank controller. Software loads an 8-bit reload value in two 4-bit pieces and then starts the timer. From the reload value the timer counts upward, one count per step, and interrupts the CPU when the count passes its all-ones value. A step is 113.75 CPU clocks long, which is close to the length of one video scanline, so the interrupt can be placed at a chosen line of the picture.

A step of fractional length comes from an accumulating prescaler. The prescaler adds a small increment on every clock. It takes away the step size whenever the sum reaches it, and the remainder carries forward. The interrupt line is a level. It stays high until software acknowledges it. After each expiry the count reloads from the latch, and the prescaler phase carries over, so the next period starts at once.

Two control bits govern the timer: a run bit and a re-arm bit. The acknowledge register copies the re-arm bit into the run bit. This allows one-shot use (re-arm clear) as well as free-running use (re-arm set).

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset the interrupt line is low. The reload value, both control bits, the count, the prescaler phase and the pending flag are zero. A start issued with no reload write first therefore takes 256 steps, which is 29120 clocks.
- R2: A write with wr_sel=0 loads wr_data[3:0] into bits 3:0 of the reload value. A write with wr_sel=1 loads wr_data[3:0] into bits 7:4. In both cases wr_data[7:4] has no effect.
- R3: A write with wr_sel=2 clears the pending flag and loads wr_data[1:0] as the control bits: bit 1 is run, bit 0 is re-arm. If wr_data[1] is 1, the count restarts from the reload value and the prescaler phase restarts from zero.
- R4: A write with wr_sel=3 clears the pending flag and copies re-arm into run. It leaves re-arm unchanged and does not restart the count or the prescaler phase.
- R5: While run is 0, the count and the prescaler phase hold, and no interrupt is raised.
- R6: After a restart with reload value L, the interrupt line rises ceil(455*(256-L)/4) clock edges after the restarting write edge. For example, L=0xFF gives 114 edges and L=0xFE gives 228 edges.
- R7: On expiry the count reloads from the reload value in the same cycle, and the prescaler remainder is kept. The k-th expiry after a restart therefore falls at ceil(455*k*(256-L)/4) edges.
- R8: The interrupt line stays high until a write with wr_sel=2 or 3. If such a write lands on the same edge as an expiry, the write wins and the line stays low.
- R9: The prescaler phase stays below the step size at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 reload low, 1 reload high, 2 control, 3 acknowledge |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Active-high interrupt request level |

## Verification
The bench builds the block with its default parameters: an 8-bit reload value, an increment of 4 and a step size of 455. Because 455 is not a multiple of 4, these values select the fractional accumulator variant. They also produce uneven step lengths of 114 and 113 clocks, so rounding errors in the carried remainder show up directly as a one-cycle shift in the interrupt edge. The 8-bit counter makes the full 256-step period of a zero reload value short enough to measure. It also makes it possible to place an acknowledge write on the exact expiry edge and to restart the timer from a prescaler phase that was frozen partway through a step.

// File: rtl/sit_pkg.sv
package sit_pkg;
   typedef enum logic [1:0] {
      SEL_RELOAD_LO = 2'd0,
      SEL_RELOAD_HI = 2'd1,
      SEL_CONTROL   = 2'd2,
      SEL_ACK       = 2'd3
   } sit_sel_e;

   localparam int CTRL_REARM = 0;
   localparam int CTRL_RUN   = 1;
endpackage

// File: rtl/sit_regs.sv
module sit_regs
   import sit_pkg::*;
#(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [LAT_W-1:0] wr_data,
   output logic [LAT_W-1:0] reload_q,
   output logic [1:0]       ctrl_q,
   output logic             restart,
   output logic             clr_pend
);
   localparam int HALF = LAT_W / 2;

   sit_sel_e sel;
   assign sel = sit_sel_e'(wr_sel);

   // each half of the reload value has its own write select
   for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk) begin
         if (!rst_n)
            reload_q[h*HALF +: HALF] <= '0;
         else if (wr_en && (wr_sel == 2'(h)))
            reload_q[h*HALF +: HALF] <= wr_data[HALF-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         if (sel == SEL_CONTROL)
            ctrl_q <= wr_data[1:0];
         else if (sel == SEL_ACK)
            ctrl_q[CTRL_RUN] <= ctrl_q[CTRL_REARM];
      end
   end

   assign restart  = wr_en && (sel == SEL_CONTROL) && wr_data[CTRL_RUN];
   assign clr_pend = wr_en && wr_sel[1];

   logic unused_hi;
   assign unused_hi = &{1'b0, wr_data[LAT_W-1:HALF]};
endmodule

// File: rtl/sit_prescaler.sv
module sit_prescaler #(
   parameter int INC   = 4,
   parameter int STEP  = 455,
   parameter int ACC_W = $clog2(STEP + INC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   output logic             tick,
   output logic [ACC_W-1:0] phase_q
);
   localparam logic [ACC_W-1:0] INC_V  = ACC_W'(INC);
   localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
   localparam logic [ACC_W-1:0] LAST_V = ACC_W'(STEP - INC);

   logic [ACC_W-1:0] phase_d;

   if ((STEP % INC) == 0) begin : g_exact
      // step is a whole number of clocks: plain wrap, no subtraction
      always_comb begin
         tick    = 1'b0;
         phase_d = phase_q;
         if (restart) begin
            phase_d = '0;
         end else if (run) begin
            if (phase_q == LAST_V) begin
               tick    = 1'b1;
               phase_d = '0;
            end else begin
               phase_d = phase_q + INC_V;
            end
         end
      end
   end else begin : g_frac
      // fractional step: remainder carries into the next step
      logic [ACC_W-1:0] sum;
      assign sum = phase_q + INC_V;
      always_comb begin
         tick    = 1'b0;
         phase_d = phase_q;
         if (restart) begin
            phase_d = '0;
         end else if (run) begin
            if (sum >= STEP_V) begin
               tick    = 1'b1;
               phase_d = sum - STEP_V;
            end else begin
               phase_d = sum;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_d;
   end
endmodule

// File: rtl/sit_counter.sv
module sit_counter #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             clr_pend,
   input  logic [LAT_W-1:0] reload_q,
   output logic [LAT_W-1:0] count_q,
   output logic             pend_q
);
   logic expire;
   assign expire = tick && (&count_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (restart || expire) begin
         count_q <= reload_q;
      end else if (tick) begin
         count_q <= count_q + 1'b1;
      end
   end

   // an acknowledge on the expiry edge takes priority
   always_ff @(posedge clk) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (clr_pend) pend_q <= 1'b0;
      else if (expire)   pend_q <= 1'b1;
   end
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
   import sit_pkg::*;
#(
   parameter int LAT_W = 8,
   parameter int INC   = 4,
   parameter int STEP  = 455
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [LAT_W-1:0] wr_data,
   output logic             irq
);
   localparam int ACC_W = $clog2(STEP + INC);

   if ((LAT_W % 2) != 0 || LAT_W < 4) begin : g_bad_width
      $error("LAT_W must be even and at least 4");
   end
   if (INC < 1 || STEP <= INC) begin : g_bad_step
      $error("STEP must exceed INC and INC must be positive");
   end

   logic [LAT_W-1:0] reload_q;
   logic [1:0]       ctrl_q;
   logic             restart;
   logic             clr_pend;
   logic             tick;
   logic [ACC_W-1:0] phase_q;
   logic [LAT_W-1:0] count_q;
   logic             pend_q;

   sit_regs #(.LAT_W(LAT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .reload_q (reload_q),
      .ctrl_q   (ctrl_q),
      .restart  (restart),
      .clr_pend (clr_pend)
   );

   sit_prescaler #(.INC(INC), .STEP(STEP), .ACC_W(ACC_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q[CTRL_RUN]),
      .restart (restart),
      .tick    (tick),
      .phase_q (phase_q)
   );

   sit_counter #(.LAT_W(LAT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .tick     (tick),
      .clr_pend (clr_pend),
      .reload_q (reload_q),
      .count_q  (count_q),
      .pend_q   (pend_q)
   );

   assign irq = pend_q;
endmodule

// File: rtl/sit_chk.sv
module sit_chk #(
   parameter int LAT_W = 8,
   parameter int INC   = 4,
   parameter int STEP  = 455,
   parameter int ACC_W = $clog2(STEP + INC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [LAT_W-1:0] wr_data,
   input logic             irq,
   input logic [LAT_W-1:0] reload_q,
   input logic [1:0]       ctrl_q,
   input logic [ACC_W-1:0] phase_q,
   input logic [LAT_W-1:0] count_q
);
   localparam int HALF = LAT_W / 2;
   localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);

   logic unused_d;
   assign unused_d = &{1'b0, wr_data[LAT_W-1:HALF]};

   // R2
   reload_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (reload_q[HALF-1:0] == $past(wr_data[HALF-1:0]))
                                  && (reload_q[LAT_W-1:HALF] == $past(reload_q[LAT_W-1:HALF])));

   // R3
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && wr_data[1]) |=> (count_q == $past(reload_q)) && (phase_q == '0));

   // R4
   ack_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> (ctrl_q[1] == $past(ctrl_q[0])) && (ctrl_q[0] == $past(ctrl_q[0])));

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel[1]) |=> !irq);

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && wr_sel[1])) |=> irq);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[1] && !irq) |=> !irq);

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[1] && !(wr_en && wr_sel == 2'd2)) |=> ($stable(phase_q) && $stable(count_q)));

   // R9
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q < STEP_V);
endmodule

bind scanline_irq_timer sit_chk #(.LAT_W(LAT_W), .INC(INC), .STEP(STEP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .irq      (irq),
   .reload_q (reload_q),
   .ctrl_q   (ctrl_q),
   .phase_q  (phase_q),
   .count_q  (count_q)
);

// File: tb/scanline_irq_timer_bench.sv
module scanline_irq_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       irq;

   int total = 0;
   int bad = 0;
   int ecount = 0;
   int ref_e = 0;
   int n = 0;

   always #2 clk = ~clk;
   always @(posedge clk) ecount <= ecount + 1;

   scanline_irq_timer u_scanline_irq_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq)
   );

   // reload value and expected edges from restart to interrupt (R6)
   localparam logic [23:0] VEC [8] = '{
      {8'hFF, 16'd114},  {8'hFE, 16'd228},  {8'hFD, 16'd342},
      {8'hFC, 16'd455},  {8'hF0, 16'd1820}, {8'hC0, 16'd7280},
      {8'h80, 16'd14560}, {8'h01, 16'd29007}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negative edge; the write lands on the next rising edge
   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic set_reload(input logic [7:0] v);
      wr(2'd0, {4'hA, v[3:0]});
      wr(2'd1, {4'h5, v[7:4]});
   endtask

   task automatic wait_irq(input int base, output int edges);
      int guard = 0;
      while (!irq && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      edges = ecount - base;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) @(negedge clk);
   endtask

   initial begin
      #(190000 * 4);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(4);
      // R1 reset state
      check(irq == 1'b0, "R1", irq, 0);
      rst_n = 1'b1;
      idle(2);
      check(irq == 1'b0, "R1", irq, 0);

      // table walk: R2 nibble loads with junk upper bits, R6 timing
      for (int v = 0; v < 8; v++) begin
         set_reload(VEC[v][23:16]);
         wr(2'd2, 8'hF2);
         ref_e = ecount;
         wait_irq(ref_e, n);
         check(n == int'(VEC[v][15:0]), "R6/R2", n, int'(VEC[v][15:0]));
         wr(2'd3, 8'h00);
         check(irq == 1'b0, "R4", irq, 0);
      end

      // periodic run, hold and acknowledge: R6 R7 R8 R4 R3 R5
      set_reload(8'hFF);
      wr(2'd2, 8'h03);
      ref_e = ecount;
      wait_irq(ref_e, n);
      check(n == 114, "R6", n, 114);
      idle(20);
      check(irq == 1'b1, "R8", irq, 1);
      wr(2'd3, 8'h00);
      check(irq == 1'b0, "R4", irq, 0);
      wait_irq(ref_e, n);
      check(n == 228, "R7", n, 228);
      wr(2'd2, 8'h00);
      check(irq == 1'b0, "R3", irq, 0);
      idle(600);
      check(irq == 1'b0, "R5", irq, 0);

      // acknowledge on the expiry edge: R8, then reload continues (R7)
      wr(2'd2, 8'h03);
      ref_e = ecount;
      while (ecount - ref_e < 113) @(negedge clk);
      wr(2'd3, 8'h00);
      check(irq == 1'b0, "R8", irq, 0);
      wait_irq(ref_e, n);
      check(n == 228, "R7", n, 228);

      // freeze mid-step then resume via acknowledge: R5 R4
      wr(2'd2, 8'h02);
      ref_e = ecount;
      while (ecount - ref_e < 49) @(negedge clk);
      wr(2'd2, 8'h00);
      idle(500);
      check(irq == 1'b0, "R5", irq, 0);
      wr(2'd2, 8'h01);
      wr(2'd3, 8'h00);
      ref_e = ecount;
      wait_irq(ref_e, n);
      check(n == 64, "R4", n, 64);

      // reset mid-run clears reload value: R1
      wr(2'd2, 8'h03);
      idle(50);
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq == 1'b0, "R1", irq, 0);
      wr(2'd2, 8'h02);
      ref_e = ecount;
      wait_irq(ref_e, n);
      check(n == 29120, "R1", n, 29120);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule